// File: doc/BRIEF.md
# Two-Line Secondary Interrupt Bank

This block gathers up to eight raw interrupt sources and presents them to two independent host interrupt lines. Each source passes through a two-stage synchroniser and an edge detector. A shared edge configuration chooses, for each source, rising, falling, both or no edge. A detected edge latches a status bit on both lines at once. Each line has its own status byte and its own mask byte. Each line drives an active-low request output while any unmasked status bit is set.

The host reaches the block through a byte-wide register port with separate read and write strobes. Read data is combinational from the current state. A control byte chooses how status is acknowledged: clear-on-read, or write-one-to-clear. The same byte can turn off the one-deep buffer that keeps a second event arriving on an already pending source. A force register lets test software set status bits directly.

Top module: `sih_bank`

## Requirements
- R1: After reset both request outputs are high. Both mask bytes read 0xFF. Both status bytes, both edge bytes and the control byte read 0x00. Address 7 reads 0x00.
- R2: Source i is configured in the edge byte at address 4 + i/4. Bit (i mod 4)*2+1 of that byte enables rising-edge detection and bit (i mod 4)*2 enables falling-edge detection. With both bits set, either edge is detected.
- R3: A source whose two edge bits are both 0 never sets a status bit, whatever its input does.
- R4: A detected edge sets status bit i in both line status bytes (line 1 at address 0, line 2 at address 2), whatever the masks hold. The bit is readable once the third rising clock edge after the input change has passed.
- R5: Line 1's mask byte is at address 1 and line 2's is at address 3; a mask bit of 1 disables that source on that line. Output irqN_n is low exactly when its line has a set status bit whose mask bit is 0.
- R6: With control bit 2 (clear-on-read) set, reading a line's status byte clears the bits it returned, on that line only. Writing a status byte has no effect in this mode.
- R7: With control bit 2 clear, writing ones to a line's status byte clears those bits on that line only. Zeros leave bits unchanged, and reading does not clear.
- R8: An event on a source whose status bit is already set is held. After the bit is cleared it is set again, and a second clear removes it. With control bit 1 set, no new event is held.
- R9: Writing the force register at address 7 sets the written one-bits in both status bytes.
- R10: If an event and a clear of the same status bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Raw asynchronous interrupt sources |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (acknowledges in clear-on-read mode) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the addressed register |
| irq1_n_o | output | 1 | Active-low request for line 1 |
| irq2_n_o | output | 1 | Active-low request for line 2 |

## Verification
The checker watches, on every cycle, that a detected edge always leaves its status bit set on both lines, even against a same-cycle clear. It also checks that a source with no edge selected never raises a bit, that a fully masked line never asserts, that a plain read outside clear-on-read mode never drops a bit, and that both outputs are high just after reset. The bench's scenarios cover the rest. These are the field position of each source in the edge bytes and the exact bits each acknowledge mode clears. They also include the reappearance of a held second event, the effect of the hold-off bit, and the per-line independence of masks and clears.

// File: rtl/sih_pkg.sv
package sih_pkg;

    localparam int REG_ADDR_W = 3;
    localparam int REG_DATA_W = 8;
    localparam int NUM_LINES  = 2;
    localparam int MAX_SRC    = 8;

    // Register map
    localparam int ADDR_EDGE0 = 4;
    localparam int ADDR_CTRL  = 6;
    localparam int ADDR_FORCE = 7;

    // Control byte fields
    localparam int CTRL_COR_BIT  = 2;
    localparam int CTRL_HOLD_BIT = 1;

    function automatic logic [REG_ADDR_W-1:0] stat_addr(input int line);
        return REG_ADDR_W'(2 * line);
    endfunction

    function automatic logic [REG_ADDR_W-1:0] mask_addr(input int line);
        return REG_ADDR_W'(2 * line + 1);
    endfunction

    function automatic logic [REG_ADDR_W-1:0] edge_addr(input int bit_idx);
        return REG_ADDR_W'(ADDR_EDGE0 + bit_idx / REG_DATA_W);
    endfunction

endpackage

// File: rtl/sih_edge_detect.sv
module sih_edge_detect #(
    parameter int NUM_SRC = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     src_i,
    input  logic [2*NUM_SRC-1:0]   edge_cfg_i,
    output logic [NUM_SRC-1:0]     event_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] meta;
        logic [NUM_SRC-1:0] sync;
        logic [NUM_SRC-1:0] prev;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.meta = src_i;
        pipe_d.sync = pipe_q.meta;
        pipe_d.prev = pipe_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic rise_w, fall_w;
        assign rise_w     = pipe_q.sync[g] & ~pipe_q.prev[g];
        assign fall_w     = ~pipe_q.sync[g] & pipe_q.prev[g];
        assign event_o[g] = (rise_w & edge_cfg_i[2*g+1]) | (fall_w & edge_cfg_i[2*g]);
    end

endmodule

// File: rtl/sih_line.sv
module sih_line #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] event_i,
    input  logic [NUM_SRC-1:0] force_i,
    input  logic [NUM_SRC-1:0] clear_i,
    input  logic               hold_off_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic               irq_n_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] pend;
    } line_t;

    line_t line_d, line_q;
    logic [NUM_SRC-1:0] set_w;
    logic [NUM_SRC-1:0] hold_w;

    assign set_w  = event_i | force_i;
    assign hold_w = event_i & {NUM_SRC{~hold_off_i}};

    always_comb begin
        line_d = line_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (line_q.status[i]) begin
                if (clear_i[i]) begin
                    // held event (or a fresh one) keeps the bit set
                    line_d.status[i] = set_w[i] | line_q.pend[i];
                    line_d.pend[i]   = line_q.pend[i] & hold_w[i];
                end else begin
                    line_d.pend[i]   = line_q.pend[i] | hold_w[i];
                end
            end else begin
                line_d.status[i] = set_w[i];
                line_d.pend[i]   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign status_o = line_q.status;
    assign irq_n_o  = ~|(line_q.status & ~mask_i);

endmodule

// File: rtl/sih_bank.sv
module sih_bank
    import sih_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_rd_i,
    input  logic [REG_DATA_W-1:0] reg_wdata_i,
    output logic [REG_DATA_W-1:0] reg_rdata_o,
    output logic                  irq1_n_o,
    output logic                  irq2_n_o
);

    localparam int EDGE_W = 2 * NUM_SRC;

    typedef struct packed {
        logic [NUM_LINES-1:0][NUM_SRC-1:0] mask;
        logic [EDGE_W-1:0]                 edge_cfg;
        logic                              cor;
        logic                              hold_off;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NUM_SRC-1:0] ev;
    logic [NUM_SRC-1:0] force_vec;
    logic [NUM_SRC-1:0] stat  [NUM_LINES];
    logic [NUM_SRC-1:0] clr   [NUM_LINES];
    logic [NUM_LINES-1:0] irq_n;

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_i) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (reg_addr_i == mask_addr(l)) begin
                    cfg_d.mask[l] = reg_wdata_i[NUM_SRC-1:0];
                end
            end
            for (int b = 0; b < EDGE_W; b++) begin
                if (reg_addr_i == edge_addr(b)) begin
                    cfg_d.edge_cfg[b] = reg_wdata_i[b % REG_DATA_W];
                end
            end
            if (reg_addr_i == REG_ADDR_W'(ADDR_CTRL)) begin
                cfg_d.cor      = reg_wdata_i[CTRL_COR_BIT];
                cfg_d.hold_off = reg_wdata_i[CTRL_HOLD_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mask     <= '1;
            cfg_q.edge_cfg <= '0;
            cfg_q.cor      <= 1'b0;
            cfg_q.hold_off <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign force_vec = (reg_wr_i && reg_addr_i == REG_ADDR_W'(ADDR_FORCE))
                       ? reg_wdata_i[NUM_SRC-1:0] : '0;

    sih_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .edge_cfg_i (cfg_q.edge_cfg),
        .event_o    (ev)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic hit_w;
        assign hit_w = (reg_addr_i == stat_addr(l));

        always_comb begin
            clr[l] = '0;
            if (hit_w && reg_rd_i && cfg_q.cor) begin
                clr[l] = stat[l];
            end else if (hit_w && reg_wr_i && !cfg_q.cor) begin
                clr[l] = reg_wdata_i[NUM_SRC-1:0];
            end
        end

        sih_line #(.NUM_SRC(NUM_SRC)) u_line (
            .clk        (clk),
            .rst        (rst),
            .event_i    (ev),
            .force_i    (force_vec),
            .clear_i    (clr[l]),
            .hold_off_i (cfg_q.hold_off),
            .mask_i     (cfg_q.mask[l]),
            .status_o   (stat[l]),
            .irq_n_o    (irq_n[l])
        );
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (reg_addr_i == stat_addr(l)) reg_rdata_o[NUM_SRC-1:0] = stat[l];
            if (reg_addr_i == mask_addr(l)) reg_rdata_o[NUM_SRC-1:0] = cfg_q.mask[l];
        end
        for (int b = 0; b < EDGE_W; b++) begin
            if (reg_addr_i == edge_addr(b)) reg_rdata_o[b % REG_DATA_W] = cfg_q.edge_cfg[b];
        end
        if (reg_addr_i == REG_ADDR_W'(ADDR_CTRL)) begin
            reg_rdata_o[CTRL_COR_BIT]  = cfg_q.cor;
            reg_rdata_o[CTRL_HOLD_BIT] = cfg_q.hold_off;
        end
    end

    assign irq1_n_o = irq_n[0];
    assign irq2_n_o = irq_n[1];

endmodule

// File: rtl/sih_bank_chk.sv
module sih_bank_chk
    import sih_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [REG_ADDR_W-1:0] reg_addr_i,
    input logic                  reg_wr_i,
    input logic                  reg_rd_i,
    input logic [NUM_SRC-1:0]    st1,
    input logic [NUM_SRC-1:0]    st2,
    input logic [NUM_SRC-1:0]    mask1,
    input logic [NUM_SRC-1:0]    mask2,
    input logic [2*NUM_SRC-1:0]  edge_cfg,
    input logic [NUM_SRC-1:0]    ev,
    input logic                  cor,
    input logic                  irq1_n,
    input logic                  irq2_n
);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq1_n && irq2_n));

    // R5
    line1_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask1 == '1) |-> irq1_n);

    // R5
    line2_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask2 == '1) |-> irq2_n);

    // R3
    no_edge_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_cfg == '0 && !(reg_wr_i && reg_addr_i == REG_ADDR_W'(ADDR_FORCE)))
        |=> (((st1 & ~$past(st1)) == '0) && ((st2 & ~$past(st2)) == '0)));

    // R4 R10
    event_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> (((st1 & $past(ev)) == $past(ev)) && ((st2 & $past(ev)) == $past(ev))));

    // R7
    plain_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (!cor && reg_rd_i && !reg_wr_i && reg_addr_i == stat_addr(0))
        |=> (($past(st1) & ~st1) == '0));

endmodule

bind sih_bank sih_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .st1        (stat[0]),
    .st2        (stat[1]),
    .mask1      (cfg_q.mask[0]),
    .mask2      (cfg_q.mask[1]),
    .edge_cfg   (cfg_q.edge_cfg),
    .ev         (ev),
    .cor        (cfg_q.cor),
    .irq1_n     (irq1_n_o),
    .irq2_n     (irq2_n_o)
);

// File: tb/sih_bank_tb.sv
module sih_bank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] src = '0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq1_n, irq2_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sih_bank #(.NUM_SRC(8)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr_en),
        .reg_rd_i    (rd_en),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq1_n_o    (irq1_n),
        .irq2_n_o    (irq2_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, int'(v), exp);
    endtask

    // change sources, wait until the status capture edge has passed
    task automatic set_src(input logic [7:0] v);
        @(negedge clk);
        src = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_both();
        wr(3'd0, 8'hFF);
        wr(3'd2, 8'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq1", int'(irq1_n), 1);
        chk("R1 irq2", int'(irq2_n), 1);
        for (int a = 0; a < 8; a++) begin
            rd_chk("R1 reg", 3'(a), (a == 1 || a == 3) ? 8'hFF : 8'h00);
        end

        // R2 R3 R4 sweep: every source, every edge mode, both directions
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 4; m++) begin
                int exp_r, exp_f;
                wr(3'd4, 8'h00);
                wr(3'd5, 8'h00);
                wr(3'(4 + i / 4), 8'(m << ((i % 4) * 2)));
                exp_r = m[1] ? (1 << i) : 0;
                exp_f = m[0] ? (1 << i) : 0;
                set_src(8'(1 << i));
                rd_chk("R2 R3 R4 rise line1", 3'd0, exp_r);
                rd_chk("R4 rise line2", 3'd2, exp_r);
                chk("R4 masked irq1", int'(irq1_n), 1);
                clear_both();
                set_src(8'h00);
                rd_chk("R2 R3 R4 fall line1", 3'd0, exp_f);
                rd_chk("R4 fall line2", 3'd2, exp_f);
                clear_both();
            end
        end

        // R5 masks per line
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        set_src(8'h05);
        chk("R5 all masked irq1", int'(irq1_n), 1);
        for (int j = 0; j < 8; j++) begin
            wr(3'd1, ~8'(1 << j));
            chk("R5 irq1 single unmask", int'(irq1_n), ((8'h05 >> j) & 1) ? 0 : 1);
            chk("R5 irq2 independent", int'(irq2_n), 1);
        end
        wr(3'd1, 8'hFF);
        wr(3'd3, 8'hFB);
        chk("R5 irq2 unmasked", int'(irq2_n), 0);
        chk("R5 irq1 masked", int'(irq1_n), 1);
        rd_chk("R5 mask2 readback", 3'd3, 8'hFB);
        wr(3'd3, 8'hFF);
        clear_both();
        set_src(8'h00);
        clear_both();

        // R7 write-one-to-clear
        set_src(8'h03);
        rd_chk("R7 read keeps a", 3'd0, 8'h03);
        rd_chk("R7 read keeps b", 3'd0, 8'h03);
        wr(3'd0, 8'h01);
        rd_chk("R7 w1c line1", 3'd0, 8'h02);
        rd_chk("R7 other line kept", 3'd2, 8'h03);
        wr(3'd0, 8'h00);
        rd_chk("R7 zero write", 3'd0, 8'h02);
        clear_both();
        rd_chk("R7 cleared", 3'd0, 8'h00);

        // R6 clear-on-read
        wr(3'd6, 8'h04);
        rd_chk("R6 ctrl readback", 3'd6, 8'h04);
        set_src(8'h00);
        wr(3'd0, 8'hFF);
        rd_chk("R6 write ignored", 3'd0, 8'h03);
        rd_chk("R6 read cleared", 3'd0, 8'h00);
        rd_chk("R6 line2 untouched", 3'd2, 8'h03);
        rd_chk("R6 line2 cleared", 3'd2, 8'h00);
        wr(3'd6, 8'h00);

        // R8 held second event
        set_src(8'h10);
        set_src(8'h00);
        wr(3'd0, 8'h10);
        rd_chk("R8 held reappears", 3'd0, 8'h10);
        wr(3'd0, 8'h10);
        rd_chk("R8 second clear", 3'd0, 8'h00);
        wr(3'd2, 8'h10);
        rd_chk("R8 held line2", 3'd2, 8'h10);
        wr(3'd2, 8'h10);
        rd_chk("R8 line2 second clear", 3'd2, 8'h00);
        wr(3'd6, 8'h02);
        set_src(8'h10);
        set_src(8'h00);
        wr(3'd0, 8'h10);
        rd_chk("R8 hold-off line1", 3'd0, 8'h00);
        wr(3'd2, 8'h10);
        rd_chk("R8 hold-off line2", 3'd2, 8'h00);

        // R9 force register
        wr(3'd7, 8'hA5);
        rd_chk("R9 force line1", 3'd0, 8'hA5);
        rd_chk("R9 force line2", 3'd2, 8'hA5);
        rd_chk("R9 force reads zero", 3'd7, 8'h00);
        clear_both();

        // R10 event and clear in the same cycle (hold-off still set)
        set_src(8'h40);
        @(negedge clk);
        src = 8'h00;
        @(posedge clk);
        @(posedge clk);
        wr(3'd0, 8'h40);
        rd_chk("R10 event wins", 3'd0, 8'h40);
        wr(3'd0, 8'h40);
        rd_chk("R10 later clear", 3'd0, 8'h00);
        rd_chk("R10 line2 set", 3'd2, 8'h40);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule